// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block sits behind a byte-wide host link and turns a stream of one-byte commands into register accesses on an internal 256-entry register space. The high four bits of each byte select an operation and the low four bits carry an argument. Because only four bits of payload arrive per byte, a full address or data value is assembled from two consecutive nibble commands. The block keeps a current address register and a pending low-data nibble, and both persist between commands.

A write is committed when the high data nibble arrives. The block then raises a one-cycle write strobe with the full address and data byte. A read command raises a one-cycle read request toward the read-side register bank. The byte that bank returns is handed back to the host one cycle later, qualified by a one-cycle valid pulse. Reads and writes go to separate banks, so the decoder drives separate address outputs for each.

After an access, the address can step by one in either direction, wrapping modulo 256. This lets a host stream through a run of registers without resending the address. Opcodes the block does not recognise leave it untouched.

Top module: `nib_reg_decoder`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `wr_en`, `rd_req` and `rsp_valid` are 0. The address register and the low data nibble both read as 0x00 and 0x0.
- R2: Opcode 0x0 replaces address bits [3:0] with the argument, and opcode 0x1 replaces address bits [7:4]. The other nibble of the address is kept.
- R3: Opcode 0x2 stores the argument as the pending low data nibble and produces no strobe. Opcode 0x3 produces `wr_en`=1 in the cycle after the command, with `wr_addr` set to the current address and `wr_data` set to {argument, pending low nibble}.
- R4: Opcode 0x4 produces `rd_req`=1 with `rd_addr` set to the current address in the cycle after the command. In the following cycle `rsp_valid`=1, and `rsp_byte` holds the `rd_data` value presented while `rd_req` was high.
- R5: For opcodes 0x3 and 0x4, argument bit 0 = 1 steps the address after the access. Argument bit 1 = 0 adds 1 and bit 1 = 1 subtracts 1, both modulo 256, with carry and borrow crossing the nibble boundary.
- R6: For opcodes 0x3 and 0x4 with argument bit 0 = 0, the address is unchanged after the access.
- R7: Opcodes 0x5 to 0xF produce no strobe and change neither the address nor the pending low data nibble.
- R8: The pending low data nibble is kept after a write, so a later opcode 0x3 alone reuses it.
- R9: A byte presented with `cmd_valid`=0 has no effect. Each accepted write or read command produces exactly one strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte qualifier |
| cmd_byte | input | 8 | Opcode in [7:4], argument in [3:0] |
| wr_en | output | 1 | One-cycle write strobe to the write bank |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| rd_req | output | 1 | One-cycle read request to the read bank |
| rd_addr | output | 8 | Read address |
| rd_data | input | 8 | Read bank data, valid while `rd_req` is high |
| rsp_valid | output | 1 | One-cycle read response qualifier |
| rsp_byte | output | 8 | Read response byte to the host |

## Verification
A corrupted address register stays hidden until the next write or read command. It then shows on `wr_addr` or `rd_addr` one cycle after that command, and on `rsp_byte` one cycle later. A wrong step direction or a lost carry appears on the very next access after a stepping command. The stimulus therefore follows every stepping access with a read, and crosses nibble boundaries in both directions, including wrap at 0x00 and 0xFF. A corrupted data nibble appears only on `wr_data`, so a write that reuses an old low nibble is included.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [NIB_W-1:0] {
    OP_ADDR_LO  = 4'h0,
    OP_ADDR_HI  = 4'h1,
    OP_DATA_LO  = 4'h2,
    OP_DATA_WR  = 4'h3,
    OP_READ     = 4'h4
  } nrd_op_e;

  localparam int unsigned ARG_STEP_BIT = 0;
  localparam int unsigned ARG_DOWN_BIT = 1;
endpackage

// File: rtl/nrd_addr_unit.sv
module nrd_addr_unit #(
  parameter int unsigned NW = 4,
  localparam int unsigned AW = 2 * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          step_en,
  input  logic          step_dn,
  input  logic [NW-1:0] nib,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] addr_d;
  logic          addr_ce;

  always_comb begin
    addr_ce = ld_lo | ld_hi | step_en;
    addr_d  = addr_q;
    if (ld_lo)        addr_d = {addr_q[AW-1:NW], nib};
    else if (ld_hi)   addr_d = {nib, addr_q[NW-1:0]};
    else if (step_en) addr_d = step_dn ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_ce) addr_q <= addr_d;
  end
endmodule

// File: rtl/nrd_data_latch.sv
module nrd_data_latch #(
  parameter int unsigned NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [NW-1:0] nib,
  output logic [NW-1:0] lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lo_q <= '0;
    else if (ld) lo_q <= nib;
  end
endmodule

// File: rtl/nrd_rsp_stage.sv
module nrd_rsp_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [DW-1:0] data_in,
  output logic          vld_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= req;
      if (req) data_q <= data_in;
    end
  end
endmodule

// File: rtl/nib_reg_decoder.sv
module nib_reg_decoder
  import nrd_pkg::*;
#(
  localparam int unsigned AW = 2 * NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_byte,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] rd_data,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_byte
);
  logic [NIB_W-1:0] op;
  logic [NIB_W-1:0] arg;
  logic             ld_lo, ld_hi, ld_dat, is_wr, is_rd;
  logic             step_en;
  logic [AW-1:0]    addr_q;
  logic [NIB_W-1:0] dat_lo_q;

  logic             wr_en_d, rd_req_d;
  logic [AW-1:0]    wr_addr_d, wr_data_d, rd_addr_d;

  assign op  = cmd_byte[AW-1:NIB_W];
  assign arg = cmd_byte[NIB_W-1:0];

  always_comb begin
    ld_lo  = 1'b0;
    ld_hi  = 1'b0;
    ld_dat = 1'b0;
    is_wr  = 1'b0;
    is_rd  = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_ADDR_LO: ld_lo  = 1'b1;
        OP_ADDR_HI: ld_hi  = 1'b1;
        OP_DATA_LO: ld_dat = 1'b1;
        OP_DATA_WR: is_wr  = 1'b1;
        OP_READ:    is_rd  = 1'b1;
        default:    ;
      endcase
    end
    step_en = (is_wr | is_rd) & arg[ARG_STEP_BIT];
  end

  nrd_addr_unit #(.NW(NIB_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .step_en (step_en),
    .step_dn (arg[ARG_DOWN_BIT]),
    .nib     (arg),
    .addr_q  (addr_q)
  );

  nrd_data_latch #(.NW(NIB_W)) u_dlo (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld_dat),
    .nib   (arg),
    .lo_q  (dat_lo_q)
  );

  always_comb begin
    wr_en_d   = is_wr;
    rd_req_d  = is_rd;
    wr_addr_d = is_wr ? addr_q : wr_addr;
    wr_data_d = is_wr ? {arg, dat_lo_q} : wr_data;
    rd_addr_d = is_rd ? addr_q : rd_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      rd_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_addr <= '0;
    end else begin
      wr_en   <= wr_en_d;
      rd_req  <= rd_req_d;
      wr_addr <= wr_addr_d;
      wr_data <= wr_data_d;
      rd_addr <= rd_addr_d;
    end
  end

  nrd_rsp_stage #(.DW(AW)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (rd_req),
    .data_in (rd_data),
    .vld_q   (rsp_valid),
    .data_q  (rsp_byte)
  );
endmodule

// File: rtl/nib_reg_decoder_chk.sv
module nib_reg_decoder_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [AW-1:0] cmd_byte,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] rd_data,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_byte
);
  localparam int unsigned NW = AW / 2;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!wr_en && !rd_req && !rsp_valid)
        else $error("reset outputs not idle");
    end
  end

  assert_wr_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cmd_valid && cmd_byte[AW-1:NW] == 4'h3));

  assert_rd_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(cmd_valid && cmd_byte[AW-1:NW] == 4'h4));

  assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(rd_req) && rsp_byte == $past(rd_data)));

  assert_unknown_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[AW-1:NW] > 4'h4) |=> (!wr_en && !rd_req));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!wr_en && !rd_req));

  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req) && !$past(cmd_byte[0], 2)) |-> rd_addr == $past(rd_addr));

  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req) && $past(cmd_byte[1:0], 2) == 2'b01)
      |-> rd_addr == $past(rd_addr) + 1'b1);

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req) && $past(cmd_byte[1:0], 2) == 2'b11)
      |-> rd_addr == $past(rd_addr) - 1'b1);
endmodule

bind nib_reg_decoder nib_reg_decoder_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .rsp_valid (rsp_valid),
  .rsp_byte  (rsp_byte)
);

// File: tb/sim_nib_reg_decoder.sv
`timescale 1ns/1ps
module sim_nib_reg_decoder;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       wr_en, rd_req, rsp_valid;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data, rsp_byte;

  int n_chk;
  int n_bad;
  int cyc;

  nib_reg_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
  );

  // read bank model: content is a fixed function of address
  assign rd_data = rd_addr ^ 8'hA5;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [7:0] cmd;
    logic       ew;
    logic [7:0] ewa;
    logic [7:0] ewd;
    logic       er;
    logic [7:0] era;
  } vec_t;

  localparam int NV = 26;
  // R2 address nibble loads, R5 stepping, R6 holding, R7 unknown opcodes, R8 nibble reuse
  localparam vec_t VEC [NV] = '{
    {8'h03, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h1A, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h25, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h3C, 1'b1, 8'hA3, 8'hC5, 1'b0, 8'h00},
    {8'h40, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA3},
    {8'h31, 1'b1, 8'hA3, 8'h15, 1'b0, 8'h00},
    {8'h41, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA4},
    {8'h43, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA5},
    {8'h73, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h40, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA4},
    {8'h0F, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h29, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h37, 1'b1, 8'hAF, 8'h79, 1'b0, 8'h00},
    {8'h40, 1'b0, 8'h00, 8'h00, 1'b1, 8'hAE},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h10, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h33, 1'b1, 8'h00, 8'h39, 1'b0, 8'h00},
    {8'h41, 1'b0, 8'h00, 8'h00, 1'b1, 8'hFF},
    {8'h40, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00},
    {8'hF5, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h3C, 1'b1, 8'h00, 8'hC9, 1'b0, 8'h00},
    {8'h12, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h40, 1'b0, 8'h00, 8'h00, 1'b1, 8'h20},
    {8'h0F, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h45, 1'b0, 8'h00, 8'h00, 1'b1, 8'h2F},
    {8'h40, 1'b0, 8'h00, 8'h00, 1'b1, 8'h30}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one byte; returns at the negedge where its strobes are visible
  task automatic send(input logic [7:0] b, input logic v);
    @(negedge clk);
    cmd_valid = v;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
  endtask

  task automatic check_vec(input vec_t e, input int idx);
    string s;
    s = $sformatf("[%0d] R3 wr_en", idx);
    chk(wr_en == e.ew, s, wr_en, e.ew);
    if (e.ew) begin
      chk(wr_addr == e.ewa, $sformatf("[%0d] R3 wr_addr", idx), wr_addr, e.ewa);
      chk(wr_data == e.ewd, $sformatf("[%0d] R3 wr_data", idx), wr_data, e.ewd);
    end
    chk(rd_req == e.er, $sformatf("[%0d] R4 rd_req", idx), rd_req, e.er);
    if (e.er)
      chk(rd_addr == e.era, $sformatf("[%0d] R4 rd_addr", idx), rd_addr, e.era);
    @(negedge clk);
    chk(!wr_en && !rd_req, $sformatf("[%0d] R9 single strobe", idx), {wr_en, rd_req}, 0);
    chk(rsp_valid == e.er, $sformatf("[%0d] R4 rsp_valid", idx), rsp_valid, e.er);
    if (e.er)
      chk(rsp_byte == (e.era ^ 8'hA5), $sformatf("[%0d] R4 rsp_byte", idx), rsp_byte, e.era ^ 8'hA5);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_byte = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk(!wr_en && !rd_req && !rsp_valid, "R1 idle in reset", {wr_en, rd_req, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: address and data nibble are zero after reset
    send(8'h30, 1'b1);
    chk(wr_en && wr_addr == 8'h00 && wr_data == 8'h00, "R1 reset address/data",
        {wr_en, wr_addr, wr_data}, 32'h10000);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].cmd, 1'b1);
      check_vec(VEC[i], i);
    end

    // R9: byte without valid is ignored (would be a write and an address change)
    send(8'h3F, 1'b0);
    chk(!wr_en && !rd_req, "R9 invalid byte no strobe", {wr_en, rd_req}, 0);
    send(8'h0A, 1'b0);
    send(8'h40, 1'b1);
    chk(rd_req && rd_addr == 8'h30, "R9 invalid byte no address change", rd_addr, 8'h30);
    @(negedge clk);

    // R7: unknown opcode does not touch pending data nibble
    send(8'h2B, 1'b1);
    send(8'h9E, 1'b1);
    chk(!wr_en && !rd_req, "R7 unknown opcode no strobe", {wr_en, rd_req}, 0);
    send(8'h34, 1'b1);
    chk(wr_en && wr_addr == 8'h30 && wr_data == 8'h4B, "R7 data nibble kept",
        {wr_addr, wr_data}, 16'h304B);
    @(negedge clk);

    // R5: back-to-back stepping reads downward across the nibble boundary
    send(8'h43, 1'b1);
    chk(rd_req && rd_addr == 8'h30, "R5 first stepping read", rd_addr, 8'h30);
    cmd_valid = 1'b1;
    cmd_byte  = 8'h43;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rd_req && rd_addr == 8'h2F, "R5 borrow into high nibble", rd_addr, 8'h2F);

    // R1: mid-run reset clears the address
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!wr_en && !rd_req && !rsp_valid, "R1 idle in second reset", {wr_en, rd_req, rsp_valid}, 0);
    rst_n = 1'b1;
    send(8'h40, 1'b1);
    chk(rd_req && rd_addr == 8'h00, "R1 address cleared", rd_addr, 8'h00);
    @(negedge clk);
    chk(rsp_valid && rsp_byte == 8'hA5, "R4 response after reset", rsp_byte, 8'hA5);

    finish_run();
  end
endmodule